// File: doc/BRIEF.md
# DMA Request-to-Channel Mapper

This block sits between a wide bank of peripheral DMA request lines and a small set of DMA channels. Every request line owns a map entry that names a target channel and carries a valid flag. Software programs the entries through a word-wide register port. When a request line changes level, the block looks up its entry. For a mapped line it moves the target channel's request level to the new value. It also sends one-cycle event pulses toward the channel status logic: request-asserted set, request-asserted clear and end-of-request set.

The map entries live in two address windows. The first 64 entries start at byte offset 0x100. The remaining entries start at byte offset 0x1100. Several request lines may change in the same clock. In that case the block applies the changes one per cycle, lowest request index first, so no edge event is merged or lost. Entries that are not valid cause request changes to be dropped. An entry write that names a channel the block does not have is refused and flagged.

Top module: `dma_req_mapper`

## Requirements
- R1: After reset every map entry reads as zero, so every request is unmapped. All channel levels are low, and no event pulse or error flag is active.
- R2: Entry n, for n from 0 to 63, is at byte address 0x100 + 4·n. A write stores bit 7 as the valid flag and bits 4:0 as the channel number. A read returns those bits in the same positions with all other bits zero.
- R3: Entry n, for n from 64 to 74, is at byte address 0x1100 + 4·(n−64). Reads of any address outside both windows return zero, and writes to such addresses change nothing.
- R4: A write with bit 7 set and a channel number not below NUM_CH is not stored. It raises map_err for exactly one cycle, the cycle after the write. A write with bit 7 clear is always stored.
- R5: A level change on a request whose entry has the valid flag clear changes no channel level and produces no event pulse.
- R6: When a mapped request goes from low to high and its channel level was low, the channel level goes high and ch_ras_set pulses for that channel. Both happen in the cycle after the clock edge at which the change is applied.
- R7: Every applied update on a mapped channel that is not a low-to-high transition of the channel level pulses ch_ras_clr for that channel instead. Updates that leave the level unchanged count as such updates.
- R8: When a mapped request goes low while its channel level is high, the channel level goes low, and ch_eor_set and ch_ras_clr pulse for that channel. The channel level always follows the most recent applied request level.
- R9: When several request lines differ from their last applied level, the block applies one per clock, in increasing request index. So at most one channel level changes per cycle.
- R10: A single request change that is present before a clock edge while no other change is pending is applied at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wdata | input | 32 | Write data; bit 7 is the valid flag and bits 4:0 are the channel |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| map_err | output | 1 | One-cycle flag for a refused entry write |
| req_in | input | 75 | Level-sensitive request lines, synchronous to clk |
| ch_level | output | 16 | Current request level of each channel |
| ch_ras_set | output | 16 | Pulse: set request-asserted status of the channel |
| ch_ras_clr | output | 16 | Pulse: clear request-asserted status of the channel |
| ch_eor_set | output | 16 | Pulse: set end-of-request status of the channel |

## Verification
Consider a map entry that holds the wrong channel or valid flag. Its next request edge moves the level of the wrong channel, or of none, and raises the matching pulse on the wrong bit one cycle after the edge is applied. A corrupted last-applied request level shows up as a change that is never applied, or as a spurious pulse, in the cycle after the bad value appears. A broken priority order shows up in the cycle-by-cycle order of channel level changes when several requests rise together. Every entry is swept through both address windows. Every channel goes through a full rise and fall, which exposes any misrouted bit within a few cycles.

// File: rtl/dma_map_pkg.sv
package dma_map_pkg;

  localparam int CHAN_FIELD_W = 5;

  typedef struct packed {
    logic                    valid;
    logic [CHAN_FIELD_W-1:0] chan;
  } map_entry_t;

  function automatic logic [7:0] entry_view(map_entry_t e);
    return {e.valid, 2'b00, e.chan};
  endfunction

endpackage

// File: rtl/dma_map_regs.sv
module dma_map_regs
  import dma_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int LO_CNT  = 64,
  parameter int LO_BASE = 'h100,
  parameter int HI_BASE = 'h1100,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  localparam int REQ_W  = $clog2(NUM_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  input  logic [REQ_W-1:0]  lk_idx,
  output map_entry_t        lk_entry
);

  localparam int HI_CNT = NUM_REQ - LO_CNT;

  map_entry_t [NUM_REQ-1:0] map_q, map_d;
  logic                     err_q, err_d;

  logic [ADDR_W-1:0] off_lo, off_hi;
  logic              lo_hit, hi_hit, hit, legal;
  logic [REQ_W-1:0]  idx;
  map_entry_t        wr_entry;
  logic              unused_wbits;

  assign unused_wbits = ^{wdata[DATA_W-1:8], wdata[6:5]};

  always_comb begin
    off_lo = addr - ADDR_W'(LO_BASE);
    off_hi = addr - ADDR_W'(HI_BASE);
    lo_hit = (addr >= ADDR_W'(LO_BASE)) && (off_lo < ADDR_W'(4 * LO_CNT)) && (addr[1:0] == 2'b00);
    hi_hit = (addr >= ADDR_W'(HI_BASE)) && (off_hi < ADDR_W'(4 * HI_CNT)) && (addr[1:0] == 2'b00);
    hit    = lo_hit || hi_hit;
    if (hi_hit) idx = REQ_W'(LO_CNT) + off_hi[REQ_W+1:2];
    else        idx = off_lo[REQ_W+1:2];
    wr_entry.valid = wdata[7];
    wr_entry.chan  = wdata[4:0];
    legal = !(wdata[7] && ({1'b0, wdata[4:0]} >= 6'(NUM_CH)));
  end

  always_comb begin
    map_d = map_q;
    err_d = 1'b0;
    if (wr && hit) begin
      if (legal) map_d[idx] = wr_entry;
      else       err_d      = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0;
      err_q <= 1'b0;
    end else begin
      map_q <= map_d;
      err_q <= err_d;
    end
  end

  assign rdata    = hit ? DATA_W'(entry_view(map_q[idx])) : '0;
  assign err      = err_q;
  assign lk_entry = map_q[lk_idx];

  assert_err_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(wr));

endmodule

// File: rtl/dma_req_picker.sv
module dma_req_picker #(
  parameter int NUM_REQ = 75,
  localparam int REQ_W  = $clog2(NUM_REQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] req_in,
  output logic               upd_valid,
  output logic [REQ_W-1:0]   upd_idx,
  output logic               upd_level
);

  logic [NUM_REQ-1:0] seen_q, seen_d, pending;

  always_comb begin
    pending   = req_in ^ seen_q;
    upd_valid = |pending;
    upd_idx   = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (pending[i]) upd_idx = REQ_W'(i);
    end
    upd_level = req_in[upd_idx];
    seen_d    = seen_q;
    if (upd_valid) seen_d[upd_idx] = upd_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (upd_valid) seen_q <= seen_d;
  end

  assert_one_apply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> $countones(seen_q ^ $past(seen_q)) == 1);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(seen_q));

endmodule

// File: rtl/dma_chan_tracker.sv
module dma_chan_tracker
  import dma_map_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  map_entry_t        upd_map,
  input  logic              upd_level,
  output logic [NUM_CH-1:0] level,
  output logic [NUM_CH-1:0] ras_set,
  output logic [NUM_CH-1:0] ras_clr,
  output logic [NUM_CH-1:0] eor_set
);

  logic [NUM_CH-1:0] lvl_q, lvl_d, rs_q, rs_d, rc_q, rc_d, eo_q, eo_d;
  logic [CH_W-1:0]   ch;
  logic              apply, old_lvl;

  always_comb begin
    ch      = upd_map.chan[CH_W-1:0];
    apply   = upd_valid && upd_map.valid && ({1'b0, upd_map.chan} < 6'(NUM_CH));
    old_lvl = lvl_q[ch];
    lvl_d   = lvl_q;
    rs_d    = '0;
    rc_d    = '0;
    eo_d    = '0;
    if (apply) begin
      lvl_d[ch] = upd_level;
      if (!old_lvl && upd_level) rs_d[ch] = 1'b1;
      else                       rc_d[ch] = 1'b1;
      if (old_lvl && !upd_level) eo_d[ch] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      rs_q  <= '0;
      rc_q  <= '0;
      eo_q  <= '0;
    end else begin
      if (apply) lvl_q <= lvl_d;
      rs_q <= rs_d;
      rc_q <= rc_d;
      eo_q <= eo_d;
    end
  end

  assign level   = lvl_q;
  assign ras_set = rs_q;
  assign ras_clr = rc_q;
  assign eor_set = eo_q;

  assert_single_level_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lvl_q ^ $past(lvl_q)) <= 1);

  assert_ras_only_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_q & ~(lvl_q & ~$past(lvl_q))) == '0);

  assert_eor_only_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eo_q & ~(~lvl_q & $past(lvl_q))) == '0);

  assert_ras_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rs_q | rc_q) && ((rs_q & rc_q) == '0));

endmodule

// File: rtl/dma_req_mapper.sv
module dma_req_mapper
  import dma_map_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16,
  parameter int LO_CNT  = 64,
  parameter int LO_BASE = 'h100,
  parameter int HI_BASE = 'h1100,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               map_err,
  input  logic [NUM_REQ-1:0] req_in,
  output logic [NUM_CH-1:0]  ch_level,
  output logic [NUM_CH-1:0]  ch_ras_set,
  output logic [NUM_CH-1:0]  ch_ras_clr,
  output logic [NUM_CH-1:0]  ch_eor_set
);

  localparam int REQ_W = $clog2(NUM_REQ);

  logic             rst_meta_q, rst_sync_q;
  logic             upd_valid, upd_level;
  logic [REQ_W-1:0] upd_idx;
  map_entry_t       upd_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dma_map_regs #(
    .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .LO_CNT(LO_CNT),
    .LO_BASE(LO_BASE), .HI_BASE(HI_BASE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .err     (map_err),
    .lk_idx  (upd_idx),
    .lk_entry(upd_map)
  );

  dma_req_picker #(.NUM_REQ(NUM_REQ)) u_picker (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .req_in   (req_in),
    .upd_valid(upd_valid),
    .upd_idx  (upd_idx),
    .upd_level(upd_level)
  );

  dma_chan_tracker #(.NUM_CH(NUM_CH)) u_track (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .upd_valid(upd_valid),
    .upd_map  (upd_map),
    .upd_level(upd_level),
    .level    (ch_level),
    .ras_set  (ch_ras_set),
    .ras_clr  (ch_ras_clr),
    .eor_set  (ch_eor_set)
  );

  assert_eor_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (ch_eor_set & ~ch_ras_clr) == '0);

endmodule

// File: tb/dma_req_mapper_tb.sv
module dma_req_mapper_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 75;
  localparam int NC = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [15:0]   reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          map_err;
  logic [NR-1:0] req_in;
  logic [NC-1:0] ch_level, ch_ras_set, ch_ras_clr, ch_eor_set;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_req_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .map_err(map_err),
    .req_in(req_in), .ch_level(ch_level), .ch_ras_set(ch_ras_set),
    .ch_ras_clr(ch_ras_clr), .ch_eor_set(ch_eor_set)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] addr_of(int n);
    if (n < 64) return 16'(32'h100 + 4 * n);
    return 16'(32'h1100 + 4 * (n - 64));
  endfunction

  task automatic wr_map(int n, logic [31:0] d, logic exp_err);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr_of(n); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R4 err flag", {31'b0, map_err}, {31'b0, exp_err});
  endtask

  task automatic rd_chk(string tag, logic [15:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  // drive one request line, then check the outputs one clock later
  task automatic step(string tag, int r, logic v, logic [NC-1:0] lvl,
                      logic [NC-1:0] rs, logic [NC-1:0] rc, logic [NC-1:0] eo);
    @(negedge clk);
    req_in[r] = v;
    @(negedge clk);
    chk({tag, " level"}, 32'(ch_level), 32'(lvl));
    chk({tag, " ras_set"}, 32'(ch_ras_set), 32'(rs));
    chk({tag, " ras_clr"}, 32'(ch_ras_clr), 32'(rc));
    chk({tag, " eor_set"}, 32'(ch_eor_set), 32'(eo));
  endtask

  task automatic quiet(string tag, logic [NC-1:0] lvl);
    @(negedge clk);
    chk({tag, " level"}, 32'(ch_level), 32'(lvl));
    chk({tag, " pulses"}, 32'(ch_ras_set | ch_ras_clr | ch_eor_set), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; req_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd_chk("R1 entry0", addr_of(0), 32'h0);
    rd_chk("R1 entry74", addr_of(74), 32'h0);
    chk("R1 level", 32'(ch_level), 32'h0);
    chk("R1 pulses", 32'(ch_ras_set | ch_ras_clr | ch_eor_set), 32'h0);
    chk("R1 err", {31'b0, map_err}, 32'h0);

    // R5: unmapped request toggles (all entries invalid after reset)
    step("R5 unmapped rise", 10, 1'b1, '0, '0, '0, '0);
    step("R5 unmapped fall", 10, 1'b0, '0, '0, '0, '0);

    // R2/R3: sweep every entry, bits 6:5 written high must read back zero
    for (int n = 0; n < NR; n++) wr_map(n, 32'hFFFF_FF60 | 32'(n % NC) | 32'h80, 1'b0);
    for (int n = 0; n < NR; n++)
      rd_chk(n < 64 ? "R2 low window" : "R3 high window", addr_of(n), 32'h80 | 32'(n % NC));

    // R3: addresses outside the windows
    rd_chk("R3 outside 0x0", 16'h0000, 32'h0);
    rd_chk("R3 outside 0x200", 16'h0200, 32'h0);
    rd_chk("R3 outside 0x112c", 16'h112C, 32'h0);
    rd_chk("R3 misaligned", 16'h0102, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 16'h0200; reg_wdata = 32'h85;
    @(negedge clk);
    reg_wr = 1'b0;
    rd_chk("R3 outside write ignored", 16'h0200, 32'h0);
    rd_chk("R3 neighbour unchanged", addr_of(63), 32'h80 | 32'(63 % NC));

    // R4: illegal channel numbers refused, valid-clear always stored
    for (int c = NC; c < 32; c++) begin
      wr_map(5, 32'h80 | 32'(c), 1'b1);
      rd_chk("R4 refused entry", addr_of(5), 32'h85);
      quiet("R4 err single cycle", '0);
      chk("R4 err drops", {31'b0, map_err}, 32'h0);
    end
    wr_map(5, 32'h14, 1'b0);
    rd_chk("R4 invalid entry stored", addr_of(5), 32'h14);

    // R5: entry with valid clear
    step("R5 invalid rise", 5, 1'b1, '0, '0, '0, '0);
    quiet("R5 invalid idle", '0);
    step("R5 invalid fall", 5, 1'b0, '0, '0, '0, '0);

    // R6/R8/R10: every channel, request 4c mapped to channel c
    for (int c = 0; c < NC; c++) begin
      wr_map(4 * c, 32'h80 | 32'(c), 1'b0);
      step("R6 rise", 4 * c, 1'b1, NC'(1) << c, NC'(1) << c, '0, '0);
      quiet("R10 pulse one cycle", NC'(1) << c);
      step("R8 fall", 4 * c, 1'b0, '0, '0, NC'(1) << c, NC'(1) << c);
    end
    // upper-window request
    wr_map(74, 32'h8F, 1'b0);
    step("R6 high req rise", 74, 1'b1, 16'h8000, 16'h8000, '0, '0);
    step("R8 high req fall", 74, 1'b0, '0, '0, 16'h8000, 16'h8000);

    // R7: two requests sharing channel 3
    wr_map(1, 32'h83, 1'b0);
    wr_map(2, 32'h83, 1'b0);
    step("R6 share first rise", 1, 1'b1, 16'h0008, 16'h0008, '0, '0);
    step("R7 share second rise", 2, 1'b1, 16'h0008, '0, 16'h0008, '0);
    step("R8 share fall latest", 1, 1'b0, '0, '0, 16'h0008, 16'h0008);
    step("R7 share low to low", 2, 1'b0, '0, '0, 16'h0008, '0);

    // R9: simultaneous rises applied lowest index first
    wr_map(7, 32'h82, 1'b0);
    wr_map(20, 32'h85, 1'b0);
    wr_map(40, 32'h89, 1'b0);
    @(negedge clk);
    req_in[40] = 1'b1; req_in[7] = 1'b1; req_in[20] = 1'b1;
    @(negedge clk);
    chk("R9 first level", 32'(ch_level), 32'h0004);
    chk("R9 first ras", 32'(ch_ras_set), 32'h0004);
    @(negedge clk);
    chk("R9 second level", 32'(ch_level), 32'h0024);
    chk("R9 second ras", 32'(ch_ras_set), 32'h0020);
    @(negedge clk);
    chk("R9 third level", 32'(ch_level), 32'h0224);
    chk("R9 third ras", 32'(ch_ras_set), 32'h0200);
    quiet("R9 drained", 16'h0224);
    req_in[40] = 1'b0; req_in[7] = 1'b0; req_in[20] = 1'b0;
    @(negedge clk);
    chk("R9 fall first eor", 32'(ch_eor_set), 32'h0004);
    @(negedge clk);
    chk("R9 fall second eor", 32'(ch_eor_set), 32'h0020);
    @(negedge clk);
    chk("R9 fall third eor", 32'(ch_eor_set), 32'h0200);
    chk("R9 fall level", 32'(ch_level), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule